// File: doc/BRIEF.md
# PLL Coefficient Search Engine

This block searches for the input divider M, the feedback multiplier N and the post-divider code PL of a phase-locked loop. It takes a requested output frequency and a reference frequency, both in kHz. Every limit is fixed by a parameter: the M range, the N range, the PL code range, the VCO window and the lowest allowed divided reference (reference / M). The search walks the PL codes in ascending order. Inside each code it walks M in ascending order, and for each M it tries a short run of N candidates. It keeps the candidate whose frequency error is smallest.

The control pins are plain and have no back-pressure. A one-cycle `start` while `busy` is low starts a search and captures both frequencies. `busy` stays high until the result is ready. `done` then pulses for exactly one cycle, and the result pins take their new values on that same edge. The result stays on the pins until the next search completes. All division is done by a single shared restoring divider, so one search takes a number of cycles that depends on the data.

Top module: `pll_coef_search`

## Requirements
- R1: After reset, `busy`, `done`, `exact` and `no_match` are 0, `rate_khz` is 0, and `m_o`/`n_o`/`pl_o` hold MAX_M, MIN_N and MIN_PL.
- R2: `start` is accepted only while `busy` is low, and `busy` rises on the next edge. A `start` seen while busy has no effect on the result. `done` is high for exactly one cycle, and `busy` falls on that same edge.
- R3: PL code k selects a post-divider ratio. For codes 0 through 14 the ratios are 1, 2, 3, 4, 5, 6, 8, 10, 12, 16, 12, 16, 20, 24, 32.
- R4: Let T = 2 × target and TV = T + floor(T/50). The effective VCO ceiling is VMAX = max(MAX_VCO, TV). PL codes run from MIN_PL up to ceil(VMAX/TV), and that upper bound is clamped into [MIN_PL, MAX_PL].
- R5: For each PL code, M runs upward from MIN_M to MAX_M. The M walk for that code stops at the first M where floor(ref/M) < MIN_U.
- R6: For a given PL code and M, let V = T × ratio and VH = V + floor(V/50). N runs from floor(V×M/ref) to ceil(VH×M/ref). An N below MIN_N is skipped, and an N above MAX_N ends the N walk. A candidate counts only if its VCO value floor(ref×N/M) lies within [MIN_VCO, VMAX].
- R7: For each counted candidate the error is |floor((VCO + floor(ratio/2))/ratio) − T|. A candidate replaces the best one only when its error is strictly smaller, so the earliest candidate in walk order wins a tie.
- R8: A zero error ends the search at once and sets `exact` to 1. `exact` is never 1 together with `no_match`.
- R9: If no candidate counts, `no_match` is 1 and the result is M = MAX_M, N = MIN_N, PL = MIN_PL.
- R10: `rate_khz` = floor(ref × N / (2 × M × ratio(PL))), computed for the reported M, N and PL.
- R11: The result pins change only on the edge where `done` is driven high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, taken while idle |
| target_khz | input | FW | Requested output frequency in kHz |
| ref_khz | input | FW | Reference frequency in kHz |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle result strobe |
| m_o | output | MW | Chosen input divider |
| n_o | output | NW | Chosen feedback multiplier |
| pl_o | output | 4 | Chosen post-divider code |
| rate_khz | output | FW | Output frequency achieved by the result |
| exact | output | 1 | Result has zero error |
| no_match | output | 1 | No candidate met the limits |

## Verification
The assertions assume that the reference and the target are nonzero. They also assume that every intermediate product (T × ratio × M, ref × N) fits in DW bits, because otherwise the range checks on M, N and PL would rest on wrapped arithmetic. The stimulus uses a small configuration with kHz values in the low thousands to low hundred-thousands and a 32-bit datapath, which keeps every product far below that width. It also includes one reference below MIN_U, which deliberately empties the M walk. A second request is pulsed only while a search is running, to show that it is ignored.

// File: rtl/coef_pkg.sv
package coef_pkg;
  localparam int PLW  = 4;
  localparam int RATW = 6;

  typedef enum logic [3:0] {
    ST_IDLE, ST_WAIT, ST_TV, ST_HPL, ST_PL, ST_VPAD, ST_MCHK, ST_U,
    ST_NLO, ST_NHI, ST_NCHK, ST_VCO, ST_LWV, ST_NEXTPL, ST_FIN, ST_RATE
  } state_e;
endpackage

// File: rtl/coef_pl_lut.sv
module coef_pl_lut
  import coef_pkg::*;
(
  input  logic [PLW-1:0]  code,
  output logic [RATW-1:0] ratio
);
  always_comb begin
    unique case (code)
      4'd0:  ratio = 6'd1;
      4'd1:  ratio = 6'd2;
      4'd2:  ratio = 6'd3;
      4'd3:  ratio = 6'd4;
      4'd4:  ratio = 6'd5;
      4'd5:  ratio = 6'd6;
      4'd6:  ratio = 6'd8;
      4'd7:  ratio = 6'd10;
      4'd8:  ratio = 6'd12;
      4'd9:  ratio = 6'd16;
      4'd10: ratio = 6'd12;
      4'd11: ratio = 6'd16;
      4'd12: ratio = 6'd20;
      4'd13: ratio = 6'd24;
      4'd14: ratio = 6'd32;
      default: ratio = 6'd1;
    endcase
  end
endmodule

// File: rtl/coef_divider.sv
module coef_divider #(
  parameter int W = 40
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] num,
  input  logic [W-1:0] den,
  output logic         done,
  output logic [W-1:0] quo
);
  localparam int CW = $clog2(W + 1);

  logic [W-1:0]  rem_q, den_q;
  logic [CW-1:0] cnt_q;
  logic          run_q;
  logic [W:0]    shifted, diff;

  assign shifted = {rem_q, quo[W-1]};
  assign diff    = shifted - {1'b0, den_q};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rem_q <= '0;
      den_q <= '0;
      quo   <= '0;
      cnt_q <= '0;
      run_q <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      if (go) begin
        rem_q <= '0;
        den_q <= den;
        quo   <= num;
        cnt_q <= CW'(W);
        run_q <= 1'b1;
      end else if (run_q) begin
        if (!diff[W]) begin
          rem_q <= diff[W-1:0];
          quo   <= {quo[W-2:0], 1'b1};
        end else begin
          rem_q <= shifted[W-1:0];
          quo   <= {quo[W-2:0], 1'b0};
        end
        cnt_q <= cnt_q - 1'b1;
        if (cnt_q == CW'(1)) begin
          run_q <= 1'b0;
          done  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pll_coef_search.sv
module pll_coef_search
  import coef_pkg::*;
#(
  parameter int MIN_M   = 1,
  parameter int MAX_M   = 255,
  parameter int MIN_N   = 8,
  parameter int MAX_N   = 255,
  parameter int MIN_PL  = 1,
  parameter int MAX_PL  = 14,
  parameter int MIN_VCO = 1000000,
  parameter int MAX_VCO = 2600000,
  parameter int MIN_U   = 12000,
  parameter int FW      = 24,
  parameter int MW      = 8,
  parameter int NW      = 8,
  parameter int DW      = 40
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           start,
  input  logic [FW-1:0]  target_khz,
  input  logic [FW-1:0]  ref_khz,
  output logic           busy,
  output logic           done,
  output logic [MW-1:0]  m_o,
  output logic [NW-1:0]  n_o,
  output logic [PLW-1:0] pl_o,
  output logic [FW-1:0]  rate_khz,
  output logic           exact,
  output logic           no_match
);
  localparam logic [DW-1:0] K_MIN_U   = DW'(MIN_U);
  localparam logic [DW-1:0] K_MIN_N   = DW'(MIN_N);
  localparam logic [DW-1:0] K_MAX_N   = DW'(MAX_N);
  localparam logic [DW-1:0] K_MIN_VCO = DW'(MIN_VCO);
  localparam logic [DW-1:0] K_MAX_VCO = DW'(MAX_VCO);
  localparam logic [DW-1:0] K_MIN_PL  = DW'(MIN_PL);
  localparam logic [DW-1:0] K_MAX_PL  = DW'(MAX_PL);
  localparam logic [DW-1:0] K_PAD     = DW'(50);

  state_e st_q, ret_q;
  logic [DW-1:0]  tgt2_q, ref_q, maxv_q, vt_q, vh_q, n_q, n2_q, best_err;
  logic [MW:0]    m_q;
  logic [PLW-1:0] pl_q, pl_hi_q, best_pl;
  logic [MW-1:0]  best_m;
  logic [NW-1:0]  best_n;
  logic           found_q;
  logic           div_go, div_done;
  logic [DW-1:0]  div_num, div_den, div_q;
  logic [RATW-1:0] rat_cur, rat_best;
  logic [DW-1:0]  rat_cur_w, rat_best_w, m_w, tv_c, maxv_c, vt_c, err_c;

  coef_divider #(.W(DW)) u_div (
    .clk(clk), .rst_n(rst_n), .go(div_go), .num(div_num), .den(div_den),
    .done(div_done), .quo(div_q)
  );
  coef_pl_lut u_lut_cur  (.code(pl_q),    .ratio(rat_cur));
  coef_pl_lut u_lut_best (.code(best_pl), .ratio(rat_best));

  assign rat_cur_w  = DW'(rat_cur);
  assign rat_best_w = DW'(rat_best);
  assign m_w        = DW'(m_q);
  assign tv_c       = tgt2_q + div_q;
  assign maxv_c     = (K_MAX_VCO > tv_c) ? K_MAX_VCO : tv_c;
  assign vt_c       = tgt2_q * rat_cur_w;
  assign err_c      = (div_q > tgt2_q) ? (div_q - tgt2_q) : (tgt2_q - div_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;   ret_q <= ST_IDLE;
      tgt2_q <= '0; ref_q <= '0; maxv_q <= '0; vt_q <= '0; vh_q <= '0;
      n_q <= '0; n2_q <= '0; best_err <= '1; m_q <= '0;
      pl_q <= '0; pl_hi_q <= '0; found_q <= 1'b0;
      best_m <= MW'(MAX_M); best_n <= NW'(MIN_N); best_pl <= PLW'(MIN_PL);
      div_go <= 1'b0; div_num <= '0; div_den <= '1;
      busy <= 1'b0; done <= 1'b0;
      m_o <= MW'(MAX_M); n_o <= NW'(MIN_N); pl_o <= PLW'(MIN_PL);
      rate_khz <= '0; exact <= 1'b0; no_match <= 1'b0;
    end else begin
      div_go <= 1'b0;
      done   <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (start) begin
          busy   <= 1'b1;
          tgt2_q <= DW'(target_khz) << 1;
          ref_q  <= DW'(ref_khz);
          best_m <= MW'(MAX_M); best_n <= NW'(MIN_N); best_pl <= PLW'(MIN_PL);
          best_err <= '1; found_q <= 1'b0;
          div_go <= 1'b1; div_num <= DW'(target_khz) << 1; div_den <= K_PAD;
          ret_q <= ST_TV; st_q <= ST_WAIT;
        end
        ST_WAIT: if (div_done) st_q <= ret_q;
        ST_TV: begin
          maxv_q <= maxv_c;
          div_go <= 1'b1; div_num <= maxv_c + tv_c - 1'b1; div_den <= tv_c;
          ret_q <= ST_HPL; st_q <= ST_WAIT;
        end
        ST_HPL: begin
          if (div_q > K_MAX_PL)      pl_hi_q <= PLW'(MAX_PL);
          else if (div_q < K_MIN_PL) pl_hi_q <= PLW'(MIN_PL);
          else                       pl_hi_q <= div_q[PLW-1:0];
          pl_q <= PLW'(MIN_PL);
          st_q <= ST_PL;
        end
        ST_PL: begin
          vt_q <= vt_c;
          div_go <= 1'b1; div_num <= vt_c; div_den <= K_PAD;
          ret_q <= ST_VPAD; st_q <= ST_WAIT;
        end
        ST_VPAD: begin
          vh_q <= vt_q + div_q;
          m_q  <= (MW+1)'(MIN_M);
          st_q <= ST_MCHK;
        end
        ST_MCHK: begin
          if (m_q > (MW+1)'(MAX_M)) st_q <= ST_NEXTPL;
          else begin
            div_go <= 1'b1; div_num <= ref_q; div_den <= m_w;
            ret_q <= ST_U; st_q <= ST_WAIT;
          end
        end
        ST_U: begin
          if (div_q < K_MIN_U) st_q <= ST_NEXTPL;
          else begin
            div_go <= 1'b1; div_num <= vt_q * m_w; div_den <= ref_q;
            ret_q <= ST_NLO; st_q <= ST_WAIT;
          end
        end
        ST_NLO: begin
          n_q <= div_q;
          div_go <= 1'b1; div_num <= vh_q * m_w + ref_q - 1'b1; div_den <= ref_q;
          ret_q <= ST_NHI; st_q <= ST_WAIT;
        end
        ST_NHI: begin
          n2_q <= div_q;
          st_q <= ST_NCHK;
        end
        ST_NCHK: begin
          if (n_q > n2_q || n_q > K_MAX_N) begin
            m_q <= m_q + 1'b1; st_q <= ST_MCHK;
          end else if (n_q < K_MIN_N) begin
            n_q <= n_q + 1'b1;
          end else begin
            div_go <= 1'b1; div_num <= ref_q * n_q; div_den <= m_w;
            ret_q <= ST_VCO; st_q <= ST_WAIT;
          end
        end
        ST_VCO: begin
          if (div_q >= K_MIN_VCO && div_q <= maxv_q) begin
            div_go <= 1'b1; div_num <= div_q + (rat_cur_w >> 1); div_den <= rat_cur_w;
            ret_q <= ST_LWV; st_q <= ST_WAIT;
          end else begin
            n_q <= n_q + 1'b1; st_q <= ST_NCHK;
          end
        end
        ST_LWV: begin
          if (err_c < best_err) begin
            best_err <= err_c; found_q <= 1'b1;
            best_m <= m_q[MW-1:0]; best_n <= n_q[NW-1:0]; best_pl <= pl_q;
          end
          if (err_c == '0) st_q <= ST_FIN;
          else begin
            n_q <= n_q + 1'b1; st_q <= ST_NCHK;
          end
        end
        ST_NEXTPL: begin
          if (pl_q >= pl_hi_q) st_q <= ST_FIN;
          else begin
            pl_q <= pl_q + 1'b1; st_q <= ST_PL;
          end
        end
        ST_FIN: begin
          div_go <= 1'b1;
          div_num <= ref_q * DW'(best_n);
          div_den <= (DW'(best_m) * rat_best_w) << 1;
          ret_q <= ST_RATE; st_q <= ST_WAIT;
        end
        ST_RATE: begin
          m_o <= best_m; n_o <= best_n; pl_o <= best_pl;
          rate_khz <= div_q[FW-1:0];
          exact    <= found_q && (best_err == '0);
          no_match <= !found_q;
          done <= 1'b1; busy <= 1'b0;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/coef_search_chk.sv
module coef_search_chk
  import coef_pkg::*;
#(
  parameter int MIN_M  = 1,
  parameter int MAX_M  = 255,
  parameter int MIN_N  = 8,
  parameter int MAX_N  = 255,
  parameter int MIN_PL = 1,
  parameter int MAX_PL = 14,
  parameter int FW     = 24,
  parameter int MW     = 8,
  parameter int NW     = 8
) (
  input logic           clk,
  input logic           rst_n,
  input logic           start,
  input logic           busy,
  input logic           done,
  input logic [MW-1:0]  m_o,
  input logic [NW-1:0]  n_o,
  input logic [PLW-1:0] pl_o,
  input logic [FW-1:0]  rate_khz,
  input logic           exact,
  input logic           no_match
);
  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R2
  AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R2
  AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start)); // R2
  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable({m_o, n_o, pl_o, rate_khz, exact, no_match})); // R11
  AST_NOMATCH_DEFAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    no_match |-> (m_o == MW'(MAX_M) && n_o == NW'(MIN_N) && pl_o == PLW'(MIN_PL))); // R9
  AST_EXACT_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    exact |-> !no_match); // R8
  AST_RESULT_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !no_match) |-> (m_o >= MW'(MIN_M) && m_o <= MW'(MAX_M) &&
                             n_o >= NW'(MIN_N) && n_o <= NW'(MAX_N))); // R6
  AST_PL_IN_LIMITS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (pl_o >= PLW'(MIN_PL) && pl_o <= PLW'(MAX_PL))); // R4
endmodule

bind pll_coef_search coef_search_chk #(
  .MIN_M(MIN_M), .MAX_M(MAX_M), .MIN_N(MIN_N), .MAX_N(MAX_N),
  .MIN_PL(MIN_PL), .MAX_PL(MAX_PL), .FW(FW), .MW(MW), .NW(NW)
) u_chk (.*);

// File: tb/pll_coef_search_bench.sv
module pll_coef_search_bench;
  localparam int MIN_M = 1, MAX_M = 3, MIN_N = 4, MAX_N = 63;
  localparam int MIN_PL = 1, MAX_PL = 14;
  localparam int MIN_VCO = 100000, MAX_VCO = 200000, MIN_U = 3500;
  localparam int FW = 24, MW = 8, NW = 8, DW = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [FW-1:0] target_khz = '0, ref_khz = '0;
  logic busy, done, exact, no_match;
  logic [MW-1:0] m_o;
  logic [NW-1:0] n_o;
  logic [3:0]    pl_o;
  logic [FW-1:0] rate_khz;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  pll_coef_search #(
    .MIN_M(MIN_M), .MAX_M(MAX_M), .MIN_N(MIN_N), .MAX_N(MAX_N),
    .MIN_PL(MIN_PL), .MAX_PL(MAX_PL), .MIN_VCO(MIN_VCO), .MAX_VCO(MAX_VCO),
    .MIN_U(MIN_U), .FW(FW), .MW(MW), .NW(NW), .DW(DW)
  ) u_pll_coef_search (
    .clk(clk), .rst_n(rst_n), .start(start), .target_khz(target_khz),
    .ref_khz(ref_khz), .busy(busy), .done(done), .m_o(m_o), .n_o(n_o),
    .pl_o(pl_o), .rate_khz(rate_khz), .exact(exact), .no_match(no_match)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint ratio_of(input longint code);
    case (code)
      0: return 1;   1: return 2;   2: return 3;   3: return 4;   4: return 5;
      5: return 6;   6: return 8;   7: return 10;  8: return 12;  9: return 16;
      10: return 12; 11: return 16; 12: return 20; 13: return 24; 14: return 32;
      default: return 1;
    endcase
  endfunction

  longint e_m, e_n, e_pl, e_ex, e_nm;

  task automatic model(input longint tgt, input longint rf);
    longint t2, tv, vmax, hp, berr;
    bit stop, found;
    t2 = 2 * tgt;
    tv = t2 + t2 / 50;
    vmax = (MAX_VCO > tv) ? MAX_VCO : tv;
    hp = (vmax + tv - 1) / tv;
    if (hp > MAX_PL) hp = MAX_PL;
    if (hp < MIN_PL) hp = MIN_PL;
    e_m = MAX_M; e_n = MIN_N; e_pl = MIN_PL;
    berr = 64'h7fff_ffff_ffff; stop = 0; found = 0;
    for (longint pl = MIN_PL; pl <= hp; pl++) begin
      longint d, vt, vh;
      if (stop) break;
      d = ratio_of(pl); vt = t2 * d; vh = vt + vt / 50;
      for (longint m = MIN_M; m <= MAX_M; m++) begin
        longint n2;
        if (stop) break;
        if (rf / m < MIN_U) break;
        n2 = (vh * m + rf - 1) / rf;
        for (longint n = vt * m / rf; n <= n2; n++) begin
          longint vco, lw, er;
          if (stop) break;
          if (n < MIN_N) continue;
          if (n > MAX_N) break;
          vco = rf * n / m;
          if (vco < MIN_VCO || vco > vmax) continue;
          lw = (vco + d / 2) / d;
          er = (lw > t2) ? lw - t2 : t2 - lw;
          if (er < berr) begin
            berr = er; found = 1; e_m = m; e_n = n; e_pl = pl;
            if (er == 0) stop = 1;
          end
        end
      end
    end
    e_ex = (found && berr == 0) ? 1 : 0;
    e_nm = found ? 0 : 1;
  endtask

  task automatic check_result(input longint rf);
    longint er;
    chk(m_o == e_m, "R5 m", m_o, e_m);
    chk(n_o == e_n, "R6 n", n_o, e_n);
    chk(pl_o == e_pl, "R4 pl", pl_o, e_pl);
    chk({m_o, n_o, pl_o} == {MW'(e_m), NW'(e_n), 4'(e_pl)}, "R7 triple", {m_o, n_o, pl_o},
        {MW'(e_m), NW'(e_n), 4'(e_pl)});
    chk(exact == e_ex, "R8 exact", exact, e_ex);
    chk(no_match == e_nm, "R9 no_match", no_match, e_nm);
    er = rf * n_o / (2 * m_o * ratio_of(pl_o));
    chk(rate_khz == er, "R3,R10 rate", rate_khz, er);
  endtask

  task automatic run_one(input longint tgt, input longint rf, input bit poke);
    logic [MW-1:0] hm; logic [NW-1:0] hn; logic [FW-1:0] hr;
    model(tgt, rf);
    @(negedge clk);
    start = 1'b1; target_khz = FW'(tgt); ref_khz = FW'(rf);
    @(negedge clk);
    start = 1'b0;
    chk(busy == 1'b1, "R2 busy after start", busy, 1);
    if (poke) begin
      repeat (3) @(negedge clk);
      start = 1'b1; target_khz = FW'(tgt * 3 + 7); ref_khz = FW'(rf + 1000);
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    chk(busy == 1'b0, "R2 busy low with done", busy, 0);
    check_result(rf);
    hm = m_o; hn = n_o; hr = rate_khz;
    @(negedge clk);
    chk(done == 1'b0, "R2 done one cycle", done, 0);
    repeat (4) @(negedge clk);
    chk({m_o, n_o, rate_khz} == {hm, hn, hr}, "R11 held", {m_o, n_o, rate_khz}, {hm, hn, hr});
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    longint refs [2] = '{10000, 12000};
    longint tgts [7] = '{1000, 3000, 10000, 12500, 20000, 33333, 120000};
    repeat (3) @(negedge clk);
    chk(busy == 0 && done == 0, "R1 idle", {busy, done}, 0);
    chk(m_o == MAX_M && n_o == MIN_N && pl_o == MIN_PL, "R1 defaults",
        {m_o, n_o, pl_o}, {MW'(MAX_M), NW'(MIN_N), 4'(MIN_PL)});
    chk(rate_khz == 0 && exact == 0 && no_match == 0, "R1 flags",
        {rate_khz, exact, no_match}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    foreach (refs[i]) foreach (tgts[j]) run_one(tgts[j], refs[i], 1'b0);
    run_one(20000, 10000, 1'b1);
    run_one(10000, 3000, 1'b0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule